// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether a twisted-pair link is healthy and gates the data path on that decision. During idle periods the far end sends short link test pulses. The block watches for them on a one-cycle strobe from the receive front end, and for a one-cycle strobe that marks the end of a good received packet. It also requests a link test pulse of its own at a fixed interval, so the far end can run the same check.

All timing is kept in ticks of a prescaled time base, normally one millisecond. In the passing state the block ignores a pulse that arrives too soon after the last pulse it accepted. It falls to the failing state when it sees neither an accepted pulse nor a packet for a whole timeout. In the failing state reception and data transmission are disabled. The block returns to passing once it has seen one complete packet or a run of consecutive pulses whose spacing falls inside a window, and only at a moment when neither direction is busy. The pulse requests keep coming in both states.

Top module: `tp_link_monitor`

## Requirements
- R1: After reset the block is in the failing state (linkPass, rxEnable and txDataEnable all low) with no consecutive pulses counted and no packet recorded.
- R2: txLinkPulse is a one-clock strobe raised once every TX_PERIOD ticks. Its counter runs freely and no state change or input affects it.
- R3: In the passing state, a pulse that arrives fewer than BLANK_MIN ticks after the last accepted pulse is ignored. It neither restarts the timeout nor becomes the reference for later spacing.
- R4: In the passing state, FAIL_TIMEOUT ticks with no accepted pulse and no rxPktDone move the block to the failing state. Each accepted pulse or packet restarts this count.
- R5: rxEnable and txDataEnable are high exactly when linkPass is high.
- R6: In the failing state, a pulse arriving CONSEC_MIN to CONSEC_MAX ticks (inclusive) after the previous pulse raises the consecutive count. A pulse outside that window, or the first pulse, sets the count to one.
- R7: The failing state is left once NEED_PULSES consecutive pulses have been counted or an rxPktDone has been seen in that state.
- R8: Leaving the failing state also requires txBusy and rxBusy to be low in the same cycle. While either is high, the qualification is held and the block stays failing.
- R9: One tick occurs every TICK_DIV clocks, so the pulse request period is TX_PERIOD*TICK_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxLinkPulse | input | 1 | One-cycle strobe: a link test pulse was received |
| rxPktDone | input | 1 | One-cycle strobe: a complete packet was received |
| txBusy | input | 1 | High while a transmission is in progress |
| rxBusy | input | 1 | High while a reception is in progress |
| txLinkPulse | output | 1 | One-cycle request to send a link test pulse |
| linkPass | output | 1 | High in the passing state, low in the failing state |
| rxEnable | output | 1 | Reception allowed |
| txDataEnable | output | 1 | Data transmission allowed |

## Verification
Recovery is tried three ways: with a packet while transmit is busy, with runs of pulses broken by one spaced too closely, and with runs broken by one spaced too far apart, ending with receive busy. Together these separate the packet path, the restart of the count below and above the window, and the busy gate. In the passing state, a pulse placed just inside the blanking interval and then silence shows whether the timeout is counted from the last accepted pulse rather than from any pulse. A packet in mid-timeout shows that packets also restart the count. A reference model stepped every clock also checks the free-running pulse request through all of these phases.

// File: rtl/tp_link_pkg.sv
package tp_link_pkg;

  typedef enum logic {
    LINK_FAIL = 1'b0,
    LINK_PASS = 1'b1
  } linkState_t;

  // strobes from the control FSM to the timer datapath
  typedef struct packed {
    logic clrIdle;
    logic clrSince;
    logic firstPulse;
    logic incConsec;
    logic clrConsec;
    logic setPkt;
    logic clrPkt;
  } linkCmd_t;

endpackage

// File: rtl/tp_link_timers.sv
module tp_link_timers
  import tp_link_pkg::*;
#(
  parameter int TICK_DIV     = 250000,
  parameter int TX_PERIOD    = 16,
  parameter int BLANK_MIN    = 5,
  parameter int FAIL_TIMEOUT = 100,
  parameter int CONSEC_MIN   = 25,
  parameter int CONSEC_MAX   = 150,
  parameter int NEED_PULSES  = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  linkCmd_t cmd,
  output logic     timeout,
  output logic     tooClose,
  output logic     inWindow,
  output logic     consecZero,
  output logic     consecDone,
  output logic     pktSeen,
  output logic     txLinkPulse
);

  localparam int TICK_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PERIOD_W = (TX_PERIOD > 1) ? $clog2(TX_PERIOD) : 1;
  localparam int IDLE_W   = $clog2(FAIL_TIMEOUT + 1);
  localparam int SINCE_SAT = CONSEC_MAX + 1;
  localparam int SINCE_W  = $clog2(SINCE_SAT + 1);
  localparam int CNT_W    = $clog2(NEED_PULSES + 1);

  localparam logic [PERIOD_W-1:0] PERIOD_LAST = PERIOD_W'(TX_PERIOD - 1);
  localparam logic [IDLE_W-1:0]   IDLE_LIMIT  = IDLE_W'(FAIL_TIMEOUT);
  localparam logic [SINCE_W-1:0]  SINCE_TOP   = SINCE_W'(SINCE_SAT);
  localparam logic [SINCE_W-1:0]  BLANK_L     = SINCE_W'(BLANK_MIN);
  localparam logic [SINCE_W-1:0]  WIN_LO      = SINCE_W'(CONSEC_MIN);
  localparam logic [SINCE_W-1:0]  WIN_HI      = SINCE_W'(CONSEC_MAX);
  localparam logic [CNT_W-1:0]    CNT_NEED    = CNT_W'(NEED_PULSES);

  logic                tick;
  logic [PERIOD_W-1:0] periodCnt;
  logic [IDLE_W-1:0]   idleCnt;
  logic [SINCE_W-1:0]  sinceCnt;
  logic [CNT_W-1:0]    consecCnt;
  logic                pktFlag;

  // millisecond-scale time base
  generate
    if (TICK_DIV > 1) begin : g_prescale
      localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_DIV - 1);
      logic [TICK_W-1:0] tickCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  tickCnt <= '0;
        else if (tickCnt == TICK_LAST) tickCnt <= '0;
        else                        tickCnt <= tickCnt + 1'b1;
      end
      assign tick = (tickCnt == TICK_LAST);

      // R9
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end else begin : g_noprescale
      assign tick = 1'b1;
    end
  endgenerate

  // free-running pulse request, independent of link state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt   <= '0;
      txLinkPulse <= 1'b0;
    end else begin
      txLinkPulse <= tick && (periodCnt == PERIOD_LAST);
      if (tick) periodCnt <= (periodCnt == PERIOD_LAST) ? '0 : periodCnt + 1'b1;
    end
  end

  // no-activity timer, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              idleCnt <= '0;
    else if (cmd.clrIdle)                   idleCnt <= '0;
    else if (tick && idleCnt != IDLE_LIMIT) idleCnt <= idleCnt + 1'b1;
  end

  // ticks since the last accepted pulse, saturating past the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              sinceCnt <= '0;
    else if (cmd.clrSince)                  sinceCnt <= '0;
    else if (tick && sinceCnt != SINCE_TOP) sinceCnt <= sinceCnt + 1'b1;
  end

  // consecutive pulse count and packet flag for recovery
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      consecCnt <= '0;
      pktFlag   <= 1'b0;
    end else begin
      if (cmd.clrConsec)                     consecCnt <= '0;
      else if (cmd.firstPulse)               consecCnt <= CNT_W'(1);
      else if (cmd.incConsec && !consecDone) consecCnt <= consecCnt + 1'b1;

      if (cmd.clrPkt)      pktFlag <= 1'b0;
      else if (cmd.setPkt) pktFlag <= 1'b1;
    end
  end

  assign timeout    = (idleCnt == IDLE_LIMIT);
  assign tooClose   = (sinceCnt < BLANK_L);
  assign inWindow   = (sinceCnt >= WIN_LO) && (sinceCnt <= WIN_HI);
  assign consecZero = (consecCnt == '0);
  assign consecDone = (consecCnt >= CNT_NEED);
  assign pktSeen    = pktFlag;

  // R6
  consec_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    consecCnt <= CNT_NEED);

  // R4
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrIdle |=> (idleCnt == '0));

  generate
    if (TX_PERIOD * TICK_DIV > 1) begin : g_pulse_chk
      // R2
      tx_pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
        txLinkPulse |=> !txLinkPulse);
    end
  endgenerate

endmodule

// File: rtl/tp_link_ctrl.sv
module tp_link_ctrl
  import tp_link_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxLinkPulse,
  input  logic     rxPktDone,
  input  logic     txBusy,
  input  logic     rxBusy,
  input  logic     timeout,
  input  logic     tooClose,
  input  logic     inWindow,
  input  logic     consecZero,
  input  logic     consecDone,
  input  logic     pktSeen,
  output linkCmd_t cmd,
  output logic     linkPass
);

  linkState_t state, nextState;
  logic       accepted;
  logic       qualified;
  logic       allIdle;

  assign accepted  = rxLinkPulse && !tooClose;
  assign qualified = consecDone || pktSeen;
  assign allIdle   = !txBusy && !rxBusy;

  always_comb begin
    cmd       = '0;
    nextState = state;
    unique case (state)
      LINK_PASS: begin
        if (accepted) begin
          cmd.clrIdle  = 1'b1;
          cmd.clrSince = 1'b1;
        end
        if (rxPktDone) cmd.clrIdle = 1'b1;
        if (timeout && !accepted && !rxPktDone) begin
          nextState     = LINK_FAIL;
          cmd.clrConsec = 1'b1;
          cmd.clrPkt    = 1'b1;
        end
      end
      default: begin
        cmd.clrIdle = 1'b1;
        if (qualified && allIdle) begin
          nextState     = LINK_PASS;
          cmd.clrSince  = 1'b1;
          cmd.clrConsec = 1'b1;
          cmd.clrPkt    = 1'b1;
        end else begin
          if (rxLinkPulse) begin
            cmd.clrSince = 1'b1;
            if (!consecZero && inWindow) cmd.incConsec  = 1'b1;
            else                         cmd.firstPulse = 1'b1;
          end
          if (rxPktDone) cmd.setPkt = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= LINK_FAIL;
    else       state <= nextState;
  end

  assign linkPass = (state == LINK_PASS);

  // R8
  idle_recover_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkPass) |-> $past(allIdle));

  // R7
  qualified_recover_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkPass) |-> $past(consecDone || pktSeen));

  // R4
  timeout_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(linkPass) |-> $past(timeout));

  // R1
  fail_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(linkPass) |-> (consecZero && !pktSeen));

endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor
  import tp_link_pkg::*;
#(
  parameter int TICK_DIV     = 250000,
  parameter int TX_PERIOD    = 16,
  parameter int BLANK_MIN    = 5,
  parameter int FAIL_TIMEOUT = 100,
  parameter int CONSEC_MIN   = 25,
  parameter int CONSEC_MAX   = 150,
  parameter int NEED_PULSES  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxLinkPulse,
  input  logic rxPktDone,
  input  logic txBusy,
  input  logic rxBusy,
  output logic txLinkPulse,
  output logic linkPass,
  output logic rxEnable,
  output logic txDataEnable
);

  linkCmd_t cmd;
  logic timeout, tooClose, inWindow, consecZero, consecDone, pktSeen;

  tp_link_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxLinkPulse(rxLinkPulse),
    .rxPktDone  (rxPktDone),
    .txBusy     (txBusy),
    .rxBusy     (rxBusy),
    .timeout    (timeout),
    .tooClose   (tooClose),
    .inWindow   (inWindow),
    .consecZero (consecZero),
    .consecDone (consecDone),
    .pktSeen    (pktSeen),
    .cmd        (cmd),
    .linkPass   (linkPass)
  );

  tp_link_timers #(
    .TICK_DIV    (TICK_DIV),
    .TX_PERIOD   (TX_PERIOD),
    .BLANK_MIN   (BLANK_MIN),
    .FAIL_TIMEOUT(FAIL_TIMEOUT),
    .CONSEC_MIN  (CONSEC_MIN),
    .CONSEC_MAX  (CONSEC_MAX),
    .NEED_PULSES (NEED_PULSES)
  ) u_timers (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .timeout    (timeout),
    .tooClose   (tooClose),
    .inWindow   (inWindow),
    .consecZero (consecZero),
    .consecDone (consecDone),
    .pktSeen    (pktSeen),
    .txLinkPulse(txLinkPulse)
  );

  assign rxEnable     = linkPass;
  assign txDataEnable = linkPass;

  // R5
  fail_gates_chk: assert property (@(posedge clk) disable iff (!rstN)
    !linkPass |-> (!rxEnable && !txDataEnable));

endmodule

// File: tb/tp_link_monitor_tb.sv
module tp_link_monitor_tb;

  localparam int TDIV = 4;
  localparam int TPER = 16;
  localparam int BLNK = 5;
  localparam int FTO  = 100;
  localparam int CMIN = 25;
  localparam int CMAX = 150;
  localparam int NEED = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLinkPulse = 1'b0, rxPktDone = 1'b0, txBusy = 1'b0, rxBusy = 1'b0;
  logic txLinkPulse, linkPass, rxEnable, txDataEnable;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  tp_link_monitor #(
    .TICK_DIV(TDIV), .TX_PERIOD(TPER), .BLANK_MIN(BLNK), .FAIL_TIMEOUT(FTO),
    .CONSEC_MIN(CMIN), .CONSEC_MAX(CMAX), .NEED_PULSES(NEED)
  ) u_dut (
    .clk(clk), .rstN(rstN), .rxLinkPulse(rxLinkPulse), .rxPktDone(rxPktDone),
    .txBusy(txBusy), .rxBusy(rxBusy), .txLinkPulse(txLinkPulse),
    .linkPass(linkPass), .rxEnable(rxEnable), .txDataEnable(txDataEnable)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model, stepped on every rising edge
  int  mTick = 0, mPer = 0, mIdle = 0, mSince = 0, mConsec = 0;
  bit  mPkt = 0, mPass = 0, mTx = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mTick = 0; mPer = 0; mIdle = 0; mSince = 0; mConsec = 0;
      mPkt = 0; mPass = 0; mTx = 0;
    end else begin
      bit tk, pass2, pkt2, acc;
      int idle2, since2, consec2, sinceInc;
      tk = (mTick == TDIV - 1);
      sinceInc = (tk && mSince < CMAX + 1) ? mSince + 1 : mSince;
      idle2 = mIdle; since2 = sinceInc; consec2 = mConsec; pkt2 = mPkt; pass2 = mPass;
      if (mPass) begin
        acc = rxLinkPulse && (mSince >= BLNK);
        if (acc || rxPktDone) idle2 = 0;
        else if (tk && mIdle < FTO) idle2 = mIdle + 1;
        if (acc) since2 = 0;
        if (mIdle >= FTO && !acc && !rxPktDone) begin
          pass2 = 0; consec2 = 0; pkt2 = 0;
        end
      end else begin
        idle2 = 0;
        if ((mConsec >= NEED || mPkt) && !txBusy && !rxBusy) begin
          pass2 = 1; since2 = 0; consec2 = 0; pkt2 = 0;
        end else begin
          if (rxLinkPulse) begin
            since2 = 0;
            if (mConsec != 0 && mSince >= CMIN && mSince <= CMAX)
              consec2 = (mConsec < NEED) ? mConsec + 1 : NEED;
            else
              consec2 = 1;
          end
          if (rxPktDone) pkt2 = 1;
        end
      end
      mTx = tk && (mPer == TPER - 1);
      if (tk) mPer = (mPer == TPER - 1) ? 0 : mPer + 1;
      mTick = tk ? 0 : mTick + 1;
      mIdle = idle2; mSince = since2; mConsec = consec2; mPkt = pkt2; mPass = pass2;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(linkPass == mPass, phase, "linkPass vs model", linkPass, mPass);
      check(rxEnable == mPass, phase, "rxEnable vs model (R5)", rxEnable, mPass);
      check(txDataEnable == mPass, phase, "txDataEnable vs model (R5)", txDataEnable, mPass);
      check(txLinkPulse == mTx, phase, "txLinkPulse vs model (R2)", txLinkPulse, mTx);
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitMs(input int n);
    waitClk(n * TDIV);
  endtask

  task automatic linkPulse();
    rxLinkPulse = 1'b1;
    @(negedge clk);
    rxLinkPulse = 1'b0;
  endtask

  task automatic pktDone();
    rxPktDone = 1'b1;
    @(negedge clk);
    rxPktDone = 1'b0;
  endtask

  initial begin
    waitClk(3);
    // R1: reset state
    check(linkPass == 1'b0, "R1", "linkPass in reset", linkPass, 0);
    rstN = 1'b1;
    waitClk(2);
    check(linkPass == 1'b0, "R1", "linkPass after reset", linkPass, 0);
    check(rxEnable == 1'b0 && txDataEnable == 1'b0, "R5", "enables after reset",
          rxEnable + txDataEnable, 0);

    // R2 / R9: pulse request period
    begin
      int gap = 0;
      phase = "R2";
      while (!txLinkPulse) @(negedge clk);
      @(negedge clk);
      gap = 1;
      while (!txLinkPulse) begin @(negedge clk); gap++; end
      check(gap == TPER * TDIV, "R9", "tx pulse period in clocks", gap, TPER * TDIV);
    end

    // R8 then R7: packet recovery gated by transmit busy
    phase = "R8";
    txBusy = 1'b1;
    pktDone();
    waitClk(20);
    check(linkPass == 1'b0, "R8", "held failing while txBusy", linkPass, 0);
    txBusy = 1'b0;
    waitClk(3);
    check(linkPass == 1'b1, "R7", "pass after packet", linkPass, 1);
    check(rxEnable == 1'b1 && txDataEnable == 1'b1, "R5", "enables in pass",
          rxEnable + txDataEnable, 2);

    // R4: silence leads to failure
    phase = "R4";
    waitMs(90);
    check(linkPass == 1'b1, "R4", "still pass at 90 ms", linkPass, 1);
    waitMs(20);
    check(linkPass == 1'b0, "R4", "fail at 110 ms", linkPass, 0);
    check(rxEnable == 1'b0, "R5", "rxEnable in fail", rxEnable, 0);

    // R6: a closely spaced pulse restarts the run
    phase = "R6";
    linkPulse();
    waitMs(30); linkPulse();
    waitMs(30); linkPulse();
    waitMs(10); linkPulse();
    waitMs(30); linkPulse();
    waitMs(30); linkPulse();
    waitClk(10);
    check(linkPass == 1'b0, "R6", "run of three after close restart", linkPass, 0);
    phase = "R7";
    waitMs(30); linkPulse();
    waitClk(5);
    check(linkPass == 1'b1, "R7", "pass after four in window", linkPass, 1);

    // R3: pulse inside blanking is ignored for the timeout
    phase = "R3";
    waitMs(16); linkPulse();
    waitMs(4); linkPulse();
    waitMs(94);
    check(linkPass == 1'b1, "R3", "pass 98 ms after accepted pulse", linkPass, 1);
    waitMs(4);
    check(linkPass == 1'b0, "R3", "fail 102 ms after accepted pulse", linkPass, 0);

    // R6: a pulse too far apart restarts the run; R8 with rxBusy
    phase = "R6";
    linkPulse();
    waitMs(30); linkPulse();
    waitMs(30); linkPulse();
    waitMs(160); linkPulse();
    waitMs(30); linkPulse();
    waitMs(30); linkPulse();
    waitClk(10);
    check(linkPass == 1'b0, "R6", "run of three after late restart", linkPass, 0);
    phase = "R8";
    rxBusy = 1'b1;
    waitMs(30); linkPulse();
    waitClk(10);
    check(linkPass == 1'b0, "R8", "held failing while rxBusy", linkPass, 0);
    rxBusy = 1'b0;
    waitClk(3);
    check(linkPass == 1'b1, "R8", "pass once idle", linkPass, 1);

    // R4: a packet restarts the timeout
    phase = "R4";
    waitMs(80);
    pktDone();
    waitMs(80);
    check(linkPass == 1'b1, "R4", "pass 80 ms after packet", linkPass, 1);
    waitMs(30);
    check(linkPass == 1'b0, "R4", "fail 110 ms after packet", linkPass, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule